// File: doc/BRIEF.md
# Push-Button Power On/Off Controller

This block holds the master power state of a smart card interface and drives it from one active-low input. The input may come from a push-button that shorts to ground or from a host's digital output. The raw level is synchronised and debounced. A press counts only after the debounced level has stayed closed for a whole debounce window.

A qualified press while the interface is off turns it on at once. A qualified press while the interface is on does not turn it off. Instead the block raises an off request to the host and gives the card sequencer a single-cycle command to deactivate. It then waits. The interface powers down only when two things are true in the same cycle: the host acknowledge is high, and the card sequencer reports that deactivation is finished.

If the acknowledge pin is left floating, a weak tie makes it follow the request. The block then acknowledges itself and powers down as soon as deactivation completes. After a power-down, the button is ignored until it has been released, so one long press can never toggle the state twice.

Top module: `pwr_button_ctrl`

## Requirements
- R1: After reset, pwr_en_o, off_req_o and deact_now_o are all 0.
- R2: A press (btn_ni low) that lasts fewer than DEBOUNCE_CYC cycles has no effect; pwr_en_o stays 0.
- R3: While off, a press held for DEBOUNCE_CYC cycles plus the synchroniser stages plus one sets pwr_en_o to 1. off_req_o stays 0.
- R4: While on, a qualified press sets off_req_o to 1 and keeps pwr_en_o at 1.
- R5: Each off request produces exactly one deact_now_o pulse, one cycle wide.
- R6: While a request is pending, the block stays on whenever off_ack_i is 0, even with deact_done_i at 1.
- R7: While a request is pending, the block stays on whenever deact_done_i is 0, even with off_ack_i at 1.
- R8: When off_ack_i and deact_done_i are both 1 during a pending request, pwr_en_o and off_req_o both fall to 0 on the next cycle.
- R9: With off_ack_i driven from off_req_o (the floating-pin tie), the block powers down on its own once deact_done_i goes high.
- R10: Holding the button after a power-up does not raise an off request until the button is released and pressed again.
- R11: A press still held when power-down completes does not power the block on again. Only a release followed by a new qualified press does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_ni | input | 1 | Raw button or host level, low means pressed |
| off_ack_i | input | 1 | Host acknowledge of the off request |
| deact_done_i | input | 1 | Card deactivation sequence finished |
| off_req_o | output | 1 | Off request to the host |
| deact_now_o | output | 1 | One-cycle command to start card deactivation |
| pwr_en_o | output | 1 | Master power enable of the interface |

## Verification
Two events compete during the pending state: the host acknowledge and the deactivation-done report. They may arrive in either order or in the same cycle. The bench raises each one alone and confirms that power stays on. It then raises both together and expects power and the request to drop within a few cycles. A second overlap is a button held through the power-down edge. The bench keeps the press down across the shutdown and confirms that power stays off until a release and a fresh press.

// File: rtl/pwr_button_pkg.sv
package pwr_button_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_REQ  = 2'd2,
    ST_PEND = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwr_btn_debounce.sv
module pwr_btn_debounce #(
  parameter int unsigned DEBOUNCE_CYC = 65536,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic pressed_o
);
  localparam int unsigned CW = $clog2(DEBOUNCE_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   pressed_q;
  logic                   samp_pressed;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= btn_ni;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], btn_ni};
    end
  endgenerate

  assign samp_pressed = ~sync_q[SYNC_STAGES-1];

  // level flips only after DEBOUNCE_CYC consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pressed_q <= 1'b0;
    end else if (samp_pressed == pressed_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DEBOUNCE_CYC - 1)) begin
      cnt_q     <= '0;
      pressed_q <= samp_pressed;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pressed_o = pressed_q;

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(DEBOUNCE_CYC));
  p_flip_qualified_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pressed_q != $past(pressed_q)) |-> ($past(samp_pressed) == pressed_q));
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_button_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic press_i,
  input  logic off_ack_i,
  input  logic deact_done_i,
  output logic off_req_o,
  output logic deact_now_o,
  output logic pwr_en_o
);
  pwr_state_e state_q, state_d;
  logic       armed_q, armed_d;

  always_comb begin
    state_d = state_q;
    armed_d = armed_q | ~press_i;
    unique case (state_q)
      ST_OFF:  if (press_i && armed_q) begin state_d = ST_ON;  armed_d = 1'b0; end
      ST_ON:   if (press_i && armed_q) begin state_d = ST_REQ; armed_d = 1'b0; end
      ST_REQ:  state_d = ST_PEND;
      ST_PEND: if (off_ack_i && deact_done_i) begin
        state_d = ST_OFF;
        armed_d = 1'b0; // release required before next power-up
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign pwr_en_o    = (state_q != ST_OFF);
  assign off_req_o   = (state_q == ST_REQ) || (state_q == ST_PEND);
  assign deact_now_o = (state_q == ST_REQ);

  p_on_needs_press_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_en_o) |-> $past(press_i));
  p_req_from_press_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(off_req_o) |-> ($past(pwr_en_o) && $past(press_i)));
  p_pulse_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_now_o |=> (!deact_now_o && off_req_o));
  p_off_needs_both_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> ($past(off_ack_i) && $past(deact_done_i)));
  p_hold_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_req_o && !(off_ack_i && deact_done_i)) |=> pwr_en_o);
  p_req_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> !off_req_o);
endmodule

// File: rtl/pwr_button_ctrl.sv
module pwr_button_ctrl #(
  parameter int unsigned DEBOUNCE_CYC = 65536,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  input  logic off_ack_i,
  input  logic deact_done_i,
  output logic off_req_o,
  output logic deact_now_o,
  output logic pwr_en_o
);
  logic pressed;

  pwr_btn_debounce #(
    .DEBOUNCE_CYC(DEBOUNCE_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_debounce (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .btn_ni   (btn_ni),
    .pressed_o(pressed)
  );

  pwr_state_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .press_i     (pressed),
    .off_ack_i   (off_ack_i),
    .deact_done_i(deact_done_i),
    .off_req_o   (off_req_o),
    .deact_now_o (deact_now_o),
    .pwr_en_o    (pwr_en_o)
  );
endmodule

// File: tb/pwr_button_ctrl_bench.sv
module pwr_button_ctrl_bench;
  localparam int unsigned DEB = 16;
  localparam int unsigned QUAL = DEB + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n = 1'b1;
  logic ack_drv = 1'b0;
  logic tie_ack = 1'b0;
  logic done = 1'b0;
  logic off_req, deact_now, pwr_en;
  logic ack;
  int   errors = 0;
  int   checks = 0;
  int   pulses = 0;

  assign ack = tie_ack ? off_req : ack_drv;

  always #4 clk = ~clk;

  pwr_button_ctrl #(.DEBOUNCE_CYC(DEB)) u_pwr_button_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(btn_n), .off_ack_i(ack),
    .deact_done_i(done), .off_req_o(off_req), .deact_now_o(deact_now),
    .pwr_en_o(pwr_en)
  );

  always @(negedge clk) if (deact_now) pulses++;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press_release(input int n);
    btn_n = 1'b0; wait_cyc(n);
    btn_n = 1'b1; wait_cyc(QUAL);
  endtask

  task automatic t_reset;
    wait_cyc(1);
    chk("R1 pwr_en", pwr_en, 1'b0);
    chk("R1 off_req", off_req, 1'b0);
    chk("R1 deact_now", deact_now, 1'b0);
  endtask

  task automatic t_short_press;
    press_release(DEB - 4);
    chk("R2 short press ignored", pwr_en, 1'b0);
  endtask

  task automatic t_power_on_hold;
    btn_n = 1'b0; wait_cyc(QUAL);
    chk("R3 pwr_en on", pwr_en, 1'b1);
    chk("R3 no request", off_req, 1'b0);
    wait_cyc(4 * DEB);
    chk("R10 held press no request", off_req, 1'b0);
    btn_n = 1'b1; wait_cyc(QUAL);
  endtask

  task automatic t_request_and_handshake;
    pulses = 0; ack_drv = 1'b0; done = 1'b0;
    press_release(QUAL);
    chk("R4 off_req high", off_req, 1'b1);
    chk("R4 pwr_en stays", pwr_en, 1'b1);
    chk("R5 single pulse", pulses == 1, 1'b1);
    ack_drv = 1'b1; wait_cyc(10);
    chk("R7 ack without done stays on", pwr_en, 1'b1);
    ack_drv = 1'b0; done = 1'b1; wait_cyc(10);
    chk("R6 done without ack stays on", pwr_en, 1'b1);
    ack_drv = 1'b1; wait_cyc(2);
    chk("R8 pwr_en off", pwr_en, 1'b0);
    chk("R8 off_req cleared", off_req, 1'b0);
    ack_drv = 1'b0; done = 1'b0; wait_cyc(4);
  endtask

  task automatic t_self_ack;
    tie_ack = 1'b1; done = 1'b0;
    press_release(QUAL);
    chk("R9 powered on", pwr_en, 1'b1);
    press_release(QUAL);
    chk("R9 request raised", off_req, 1'b1);
    chk("R9 waits for done", pwr_en, 1'b1);
    done = 1'b1; wait_cyc(3);
    chk("R9 self powered off", pwr_en, 1'b0);
    done = 1'b0; tie_ack = 1'b0; wait_cyc(4);
  endtask

  task automatic t_hold_across_off;
    press_release(QUAL);
    chk("R11 powered on", pwr_en, 1'b1);
    pulses = 0; ack_drv = 1'b1; done = 1'b1;
    btn_n = 1'b0; wait_cyc(QUAL + 4 * DEB);
    chk("R11 off while held", pwr_en, 1'b0);
    chk("R5 one pulse on held press", pulses == 1, 1'b1);
    btn_n = 1'b1; wait_cyc(QUAL);
    chk("R11 release keeps off", pwr_en, 1'b0);
    ack_drv = 1'b0; done = 1'b0;
    press_release(QUAL);
    chk("R11 fresh press on", pwr_en, 1'b1);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_short_press();
    t_power_on_hold();
    t_request_and_handshake();
    t_self_ack();
    t_hold_across_off();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule